// File: doc/BRIEF.md
# Streaming Q-less QR Triangularizer

This block takes the rows of a complex fixed-point matrix A (M rows, N columns, M >= N >= 2) one at a time and folds each row into an upper-triangular factor R. Q is never formed. Each row is cleared one column at a time with complex Givens rotations. For a column k, the block first strips the phase of the row's element k and applies the same phase turn to the rest of the row. It then rotates the now real pair (R[k][k], row element k) to zero the row element, and applies that same rotation to the real and imaginary parts of the rest of R row k and the input row. One iterative shift-and-add rotator does all of this work, one step per clock. The rotation angle is never computed. The direction bits found while vectoring are stored and replayed to rotate the other elements.

A non-negative regularization value lambda can be supplied. At the first row of each matrix, R is seeded with lambda times the identity. The result then satisfies R^H R = lambda^2 I + A^H A. When the last row of a matrix has been absorbed, the block pulses a done strobe. R then stays steady on its outputs until the first row of the next matrix is accepted.

Rows enter over a valid/ready handshake. A row moves only at a rising edge where both in_valid_i and in_ready_o are high. in_ready_o falls in the next cycle and stays low for the whole rotation sequence of that row, so the source simply holds its next row until ready returns. The block never buffers a second row. A synchronous restart drops any work in progress and clears R.

Top module: `qrt_triang`

## Requirements
- R1: After rst_n is sampled low at a rising edge: in_ready_o is 1, r_done_o is 0, and every bit of r_re_o and r_im_o is 0.
- R2: A row is captured only at a rising edge where in_valid_i and in_ready_o are both 1. While in_valid_i is 0, changes on a_re_i, a_im_i and lambda_i leave R unchanged, leave in_ready_o high, and never pulse r_done_o.
- R3: In the cycle after a row is accepted, in_ready_o is 0. It stays 0 while that row is processed and is 1 again no more than N+2+OPS*(ITER+3) cycles after acceptance, where OPS = 2N + 3N(N-1)/2.
- R4: r_done_o is 1 for exactly one cycle. That cycle is the one in which in_ready_o returns after the M-th row of a matrix. r_done_o is 0 when ready returns after any other row.
- R5: Column c of a row is read from bits [c*DW +: DW] of a_re_i and a_im_i, in two's complement. Element (i,j) of R is at bits [(i*N+j)*RW +: RW] of r_re_o and r_im_o, with RW = DW+7 and 4 more fractional bits than the inputs. With lambda 0, each entry of R at done matches the upper Cholesky factor of A^H A (real positive diagonal) to within 0.02.
- R6: At all times, the entries of R below the diagonal are zero, the imaginary parts of the diagonal are zero, and the real parts of the diagonal are non-negative.
- R7: lambda_i uses the same format as an input element and is sampled when the first row of a matrix is accepted. R then matches the Cholesky factor of lambda^2 I + A^H A to within 0.02. Changes to lambda_i after that first row have no effect on the matrix.
- R8: restart_i high at a rising edge aborts the row in progress. In the next cycle R is all zero and r_done_o is 0. in_ready_o is 0 while restart_i is high and 1 once it is low. The next accepted row is the first row of a new matrix.
- R9: From the r_done_o cycle until the next row is accepted, r_re_o and r_im_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_i | input | 1 | Abort current matrix and clear R |
| in_valid_i | input | 1 | Row on a_re_i/a_im_i is valid |
| in_ready_o | output | 1 | Block can take a row this cycle |
| a_re_i | input | N*DW | Real parts of one row of A, column c at [c*DW +: DW] |
| a_im_i | input | N*DW | Imaginary parts of one row of A |
| lambda_i | input | DW | Non-negative regularization value, input format |
| r_done_o | output | 1 | One-cycle strobe: R holds the finished factor |
| r_re_o | output | N*N*RW | Real parts of R, element (i,j) at [(i*N+j)*RW +: RW] |
| r_im_o | output | N*N*RW | Imaginary parts of R, same layout |

## Verification
in_ready_o is due low one cycle after the edge that accepts a row. It is due high again 1+N+OPS*(ITER+3) cycles later: one cycle to accept, one set-up cycle per column, and ITER+3 cycles for each rotator operation. After the M-th row, r_done_o is due in that same cycle and must be gone one cycle later. The bench drives inputs on falling edges and samples on falling edges. It checks ready one cycle after acceptance, then counts falling edges until ready returns and compares that count with the R3 bound. It samples done in the return cycle and in the cycle after. It compares R against a floating-point Cholesky factor right after done, and again after a long idle gap and after a restart.

// File: rtl/qrt_pkg.sv
package qrt_pkg;
  typedef enum logic [1:0] {S_IDLE, S_PREP, S_ISSUE, S_WAIT} qrt_state_t;
  // rotator job kinds: phase vectoring, phase replay, magnitude vectoring,
  // magnitude replay on real parts, magnitude replay on imaginary parts
  typedef enum logic [2:0] {OP_VPH, OP_RPH, OP_VMG, OP_RRE, OP_RIM} qrt_op_t;
endpackage

// File: rtl/qrt_cordic.sv
module qrt_cordic #(
  parameter int CW   = 25,
  parameter int OW   = 23,
  parameter int ITER = 16,
  parameter int KF   = 16,
  parameter int KINV = 39797
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 start_i,
  input  logic                 vec_i,
  input  logic signed [CW-1:0] x_i,
  input  logic signed [CW-1:0] y_i,
  output logic                 done_o,
  output logic signed [OW-1:0] x_o,
  output logic signed [OW-1:0] y_o
);
  localparam int NW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [NW-1:0] NLAST = NW'(ITER - 1);
  localparam logic signed [KF:0] KS = (KF + 1)'(KINV);

  logic signed [CW-1:0] x, y, xn, yn;
  logic [ITER-1:0] dirs;
  logic [NW-1:0] cnt;
  logic run, fin, vec, dnow;
  logic signed [CW+KF:0] xe, ye;

  always_comb begin
    dnow = vec ? !y[CW-1] : dirs[cnt];
    xn = dnow ? x + (y >>> cnt) : x - (y >>> cnt);
    yn = dnow ? y - (x >>> cnt) : y + (x >>> cnt);
    xe = {{(KF + 1){x[CW-1]}}, x};
    ye = {{(KF + 1){y[CW-1]}}, y};
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      x <= '0; y <= '0; dirs <= '0; cnt <= '0;
      run <= 1'b0; fin <= 1'b0; vec <= 1'b0;
      done_o <= 1'b0; x_o <= '0; y_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        x <= x_i; y <= y_i; vec <= vec_i; cnt <= '0; run <= 1'b1;
      end else if (run) begin
        x <= xn; y <= yn;
        if (vec) dirs[cnt] <= dnow;
        if (cnt == NLAST) begin
          run <= 1'b0; fin <= 1'b1;
        end
        cnt <= cnt + 1'b1;
      end else if (fin) begin
        fin <= 1'b0;
        x_o <= OW'((xe * KS) >>> KF);
        y_o <= OW'((ye * KS) >>> KF);
        done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qrt_triang.sv
module qrt_triang
  import qrt_pkg::*;
#(
  parameter int M    = 4,
  parameter int N    = 4,
  parameter int DW   = 16,
  parameter int HB   = 3,
  parameter int GB   = 4,
  parameter int ITER = 16,
  parameter int KF   = 16,
  parameter int KINV = 39797
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart_i,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic [N*DW-1:0]            a_re_i,
  input  logic [N*DW-1:0]            a_im_i,
  input  logic [DW-1:0]              lambda_i,
  output logic                       r_done_o,
  output logic [N*N*(DW+HB+GB)-1:0]  r_re_o,
  output logic [N*N*(DW+HB+GB)-1:0]  r_im_o
);
  localparam int RW  = DW + HB + GB;
  localparam int CW  = RW + 2;
  localparam int KW  = $clog2(N);
  localparam int RCW = $clog2(M);
  localparam logic [KW-1:0]  KLAST = KW'(N - 1);
  localparam logic [RCW-1:0] RLAST = RCW'(M - 1);

  qrt_state_t st;
  qrt_op_t    op;
  logic [KW-1:0]  k, j;
  logic [RCW-1:0] rows;
  logic signed [RW-1:0] rre [N][N];
  logic signed [RW-1:0] rim [N][N];
  logic signed [RW-1:0] xr [N];
  logic signed [RW-1:0] xi [N];

  logic c_start, c_vec, c_done;
  logic signed [CW-1:0] c_xi, c_yi;
  logic signed [RW-1:0] c_x, c_y;

  function automatic logic signed [RW-1:0] widen(input logic [DW-1:0] v);
    return {{HB{v[DW-1]}}, v, {GB{1'b0}}};
  endfunction

  function automatic logic signed [CW-1:0] ext(input logic signed [RW-1:0] v);
    return {{(CW - RW){v[RW-1]}}, v};
  endfunction

  assign in_ready_o = (st == S_IDLE) && !restart_i;
  assign c_start    = (st == S_ISSUE);

  always_comb begin
    c_vec = 1'b0;
    c_xi  = ext(rre[k][j]);
    c_yi  = ext(xr[j]);
    case (op)
      OP_VPH:  begin c_vec = 1'b1; c_xi = ext(xr[k]);     c_yi = ext(xi[k]); end
      OP_RPH:  begin               c_xi = ext(xr[j]);     c_yi = ext(xi[j]); end
      OP_VMG:  begin c_vec = 1'b1; c_xi = ext(rre[k][k]); c_yi = ext(xr[k]); end
      OP_RIM:  begin               c_xi = ext(rim[k][j]); c_yi = ext(xi[j]); end
      default: ;
    endcase
  end

  qrt_cordic #(.CW(CW), .OW(RW), .ITER(ITER), .KF(KF), .KINV(KINV)) u_rot (
    .clk(clk), .clr(!rst_n || restart_i), .start_i(c_start), .vec_i(c_vec),
    .x_i(c_xi), .y_i(c_yi), .done_o(c_done), .x_o(c_x), .y_o(c_y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) begin
      st <= S_IDLE; op <= OP_VPH; k <= '0; j <= '0; rows <= '0; r_done_o <= 1'b0;
      for (int a = 0; a < N; a++) begin
        xr[a] <= '0; xi[a] <= '0;
        for (int b = 0; b < N; b++) begin rre[a][b] <= '0; rim[a][b] <= '0; end
      end
    end else begin
      r_done_o <= 1'b0;
      case (st)
        S_IDLE: if (in_valid_i) begin
          for (int a = 0; a < N; a++) begin
            xr[a] <= widen(a_re_i[a*DW +: DW]);
            xi[a] <= widen(a_im_i[a*DW +: DW]);
          end
          if (rows == '0) begin
            for (int a = 0; a < N; a++)
              for (int b = 0; b < N; b++) begin
                rre[a][b] <= (a == b) ? widen(lambda_i) : '0;
                rim[a][b] <= '0;
              end
          end
          k  <= '0;
          st <= S_PREP;
        end
        S_PREP: begin
          // keep the vectoring input in the right half plane
          if (xr[k][RW-1]) begin
            for (int a = 0; a < N; a++) begin xr[a] <= -xr[a]; xi[a] <= -xi[a]; end
          end
          op <= OP_VPH;
          st <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (c_done) begin
          st <= S_ISSUE;
          case (op)
            OP_VPH: begin
              xr[k] <= c_x; xi[k] <= '0;
              if (k == KLAST) op <= OP_VMG;
              else begin op <= OP_RPH; j <= k + 1'b1; end
            end
            OP_RPH: begin
              xr[j] <= c_x; xi[j] <= c_y;
              if (j == KLAST) op <= OP_VMG;
              else j <= j + 1'b1;
            end
            OP_VMG: begin
              rre[k][k] <= c_x;
              if (k == KLAST) begin
                st <= S_IDLE;
                if (rows == RLAST) begin rows <= '0; r_done_o <= 1'b1; end
                else rows <= rows + 1'b1;
              end else begin
                op <= OP_RRE; j <= k + 1'b1;
              end
            end
            OP_RRE: begin
              rre[k][j] <= c_x; xr[j] <= c_y; op <= OP_RIM;
            end
            default: begin
              rim[k][j] <= c_x; xi[j] <= c_y;
              if (j == KLAST) begin k <= k + 1'b1; st <= S_PREP; end
              else begin op <= OP_RRE; j <= j + 1'b1; end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar a = 0; a < N; a++) begin : g_row
    for (genvar b = 0; b < N; b++) begin : g_col
      assign r_re_o[(a*N+b)*RW +: RW] = rre[a][b];
      assign r_im_o[(a*N+b)*RW +: RW] = rim[a][b];
    end
  end
endmodule

// File: rtl/qrt_triang_chk.sv
module qrt_triang_chk #(
  parameter int N  = 4,
  parameter int RW = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              r_done_o,
  input logic [N*N*RW-1:0] r_re_o,
  input logic [N*N*RW-1:0] r_im_o
);
  // R2, R9: nothing moves while idle and no row is offered
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready_o && !in_valid_i) |=> ($stable(r_re_o) && $stable(r_im_o) && !r_done_o));

  // R3: an accepted row drops ready in the next cycle
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  // R4: done is a single-cycle strobe
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    r_done_o |=> !r_done_o);

  // R4: done appears together with ready
  a_r4_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    r_done_o |-> (in_ready_o || restart_i));

  // R8: restart clears R and done
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (r_re_o == '0 && r_im_o == '0 && !r_done_o && (restart_i || in_ready_o)));

  // R6: triangular shape, real non-negative diagonal
  for (genvar a = 0; a < N; a++) begin : g_r
    for (genvar b = 0; b < N; b++) begin : g_c
      if (b < a) begin : g_low
        a_r6_lower_zero: assert property (@(posedge clk) disable iff (!rst_n)
          (r_re_o[(a*N+b)*RW +: RW] == '0 && r_im_o[(a*N+b)*RW +: RW] == '0));
      end else if (b == a) begin : g_dia
        a_r6_diag_real: assert property (@(posedge clk) disable iff (!rst_n)
          (r_im_o[(a*N+b)*RW +: RW] == '0 && !r_re_o[(a*N+b)*RW + RW - 1]));
      end
    end
  end
endmodule

bind qrt_triang qrt_triang_chk #(.N(N), .RW(DW + HB + GB)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .r_done_o(r_done_o), .r_re_o(r_re_o), .r_im_o(r_im_o)
);

// File: tb/qrt_triang_tb.sv
`timescale 1ns/1ps
module qrt_triang_tb;
  localparam int M = 4, N = 4, DW = 16, RW = 23, ITER = 16;
  localparam real INSC = 4096.0;
  localparam real RSC  = 65536.0;
  localparam int OPS   = 2*N + 3*N*(N-1)/2;
  localparam int BOUND = N + 2 + OPS*(ITER+3);

  logic clk = 1'b0, rst_n = 1'b0, restart_i = 1'b0, in_valid_i = 1'b0;
  logic [N*DW-1:0] a_re_i = '0, a_im_i = '0;
  logic [DW-1:0] lambda_i = '0;
  logic in_ready_o, r_done_o;
  logic [N*N*RW-1:0] r_re_o, r_im_o;

  qrt_triang u_dut (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .a_re_i(a_re_i), .a_im_i(a_im_i), .lambda_i(lambda_i),
    .r_done_o(r_done_o), .r_re_o(r_re_o), .r_im_o(r_im_o)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  real ar [M][N];
  real ai [M][N];
  real er [N][N];
  real ei [N][N];
  logic [N*N*RW-1:0] snap_re, snap_im;

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%f expected=%f", req, what, act, exp);
    end
  endtask

  function automatic real rget(input logic [N*N*RW-1:0] v, input int i, input int j);
    logic signed [RW-1:0] s;
    s = v[(i*N+j)*RW +: RW];
    return $itor(s) / RSC;
  endfunction

  function automatic logic [DW-1:0] code(input real v);
    int c;
    c = $rtoi(v * INSC);
    return c[DW-1:0];
  endfunction

  task automatic load_mat(input int sel);
    for (int i = 0; i < M; i++)
      for (int j = 0; j < N; j++) begin
        if (sel == 0) begin
          ar[i][j] = (i == j) ? 1.5 : 0.125 * (i - j);
          ai[i][j] = 0.0;
        end else begin
          ar[i][j] = 0.125 * (((i + 2*j) % 5) - 2) + ((i == j) ? ((i % 2) ? -1.5 : 1.5) : 0.0);
          ai[i][j] = 0.125 * (((3*i + j) % 4) - 1.5) + ((i == j && i == 2) ? 0.75 : 0.0);
        end
      end
  endtask

  // upper Cholesky factor of lam^2 I + A^H A
  task automatic ref_chol(input real lam);
    real gr [N][N];
    real gi [N][N];
    real sr, si;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        sr = (i == j) ? lam * lam : 0.0;
        si = 0.0;
        for (int r = 0; r < M; r++) begin
          sr += ar[r][i] * ar[r][j] + ai[r][i] * ai[r][j];
          si += ar[r][i] * ai[r][j] - ai[r][i] * ar[r][j];
        end
        gr[i][j] = sr; gi[i][j] = si;
        er[i][j] = 0.0; ei[i][j] = 0.0;
      end
    for (int i = 0; i < N; i++) begin
      sr = gr[i][i];
      for (int q = 0; q < i; q++) sr -= er[q][i]*er[q][i] + ei[q][i]*ei[q][i];
      er[i][i] = $sqrt(sr);
      for (int j = i + 1; j < N; j++) begin
        sr = gr[i][j]; si = gi[i][j];
        for (int q = 0; q < i; q++) begin
          sr -= er[q][i]*er[q][j] + ei[q][i]*ei[q][j];
          si -= er[q][i]*ei[q][j] - ei[q][i]*er[q][j];
        end
        er[i][j] = sr / er[i][i]; ei[i][j] = si / er[i][i];
      end
    end
  endtask

  task automatic cmp_r(input string req);
    real gr, gi;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        gr = rget(r_re_o, i, j); gi = rget(r_im_o, i, j);
        chk(gr - er[i][j] < 0.02 && er[i][j] - gr < 0.02, req, $sformatf("R re(%0d,%0d)", i, j), gr, er[i][j]);
        chk(gi - ei[i][j] < 0.02 && ei[i][j] - gi < 0.02, req, $sformatf("R im(%0d,%0d)", i, j), gi, ei[i][j]);
        if (j < i) chk(gr == 0.0 && gi == 0.0, "R6", "below diagonal", gr, 0.0);
        if (j == i) chk(gi == 0.0 && gr >= 0.0, "R6", "diagonal real", gi, 0.0);
      end
  endtask

  task automatic put_row(input int r);
    for (int j = 0; j < N; j++) begin
      a_re_i[j*DW +: DW] = code(ar[r][j]);
      a_im_i[j*DW +: DW] = code(ai[r][j]);
    end
  endtask

  // offer a row, then follow ready through its rotation sequence
  task automatic send_row(input int r, input bit last);
    int cyc;
    @(negedge clk); put_row(r); in_valid_i = 1'b1;
    @(negedge clk); in_valid_i = 1'b0;
    chk(!in_ready_o, "R3", "ready low after accept", in_ready_o, 0);
    cyc = 1;
    while (!in_ready_o && cyc < BOUND + 2) begin @(negedge clk); cyc++; end
    chk(in_ready_o && cyc <= BOUND, "R3", "ready return cycles", cyc, BOUND);
    chk(r_done_o == last, "R4", $sformatf("done after row %0d", r), r_done_o, last);
    if (last) begin
      @(negedge clk);
      chk(!r_done_o, "R4", "done one cycle", r_done_o, 0);
    end
  endtask

  task automatic t_reset;
    chk(in_ready_o, "R1", "ready after reset", in_ready_o, 1);
    chk(!r_done_o, "R1", "done after reset", r_done_o, 0);
    chk(r_re_o == '0 && r_im_o == '0, "R1", "R zero after reset", 0, 0);
  endtask

  task automatic t_idle_ignore;
    int seen;
    seen = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      a_re_i = {N{16'h1234 + 16'(c)}}; a_im_i = ~a_re_i; lambda_i = 16'(c * 100);
      if (r_done_o || !in_ready_o) seen++;
    end
    @(negedge clk);
    chk(seen == 0, "R2", "ready/done while idle", seen, 0);
    chk(r_re_o == '0 && r_im_o == '0, "R2", "R untouched with valid low", 0, 0);
  endtask

  task automatic t_matrix(input int sel, input real lam, input bit wiggle, input string req);
    load_mat(sel);
    lambda_i = code(lam);
    for (int r = 0; r < M; r++) begin
      send_row(r, r == M - 1);
      if (wiggle) lambda_i = code(lam + 1.0);
    end
    ref_chol(lam);
    cmp_r(req);
  endtask

  task automatic t_hold;
    snap_re = r_re_o; snap_im = r_im_o;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk); a_re_i = ~a_re_i; lambda_i = 16'h0800;
    end
    chk(r_re_o == snap_re && r_im_o == snap_im, "R9", "R held after done", 0, 0);
    chk(in_ready_o && !r_done_o, "R9", "idle after done", in_ready_o, 1);
  endtask

  task automatic t_restart;
    load_mat(1);
    lambda_i = '0;
    send_row(0, 1'b0);
    send_row(1, 1'b0);
    @(negedge clk); put_row(2); in_valid_i = 1'b1;
    @(negedge clk); in_valid_i = 1'b0;
    repeat (7) @(negedge clk);
    restart_i = 1'b1;
    #1 chk(!in_ready_o, "R8", "ready low during restart", in_ready_o, 0);
    @(negedge clk); restart_i = 1'b0;
    #1 chk(in_ready_o, "R8", "ready after restart", in_ready_o, 1);
    chk(r_re_o == '0 && r_im_o == '0 && !r_done_o, "R8", "R cleared by restart", 0, 0);
    t_matrix(0, 0.0, 1'b0, "R8");
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_matrix(0, 0.0, 1'b0, "R5");
    t_hold();
    t_matrix(1, 0.0, 1'b0, "R5");
    t_matrix(1, 0.5, 1'b1, "R7");
    t_restart();
    t_matrix(0, 0.75, 1'b0, "R7");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule